// File: doc/BRIEF.md
# Bus-Master Latency Timer with Configuration Dword

This block holds the latency setting of a bus master and counts down the time the master may keep the bus. It sits beside the master interface and has one 32-bit configuration dword that configuration software reads and writes by byte lane. Only the latency byte can be written. The other three bytes are fixed: the header byte comes from a strap pin, and the self-test and cache-line bytes read as zero.

When the master starts a transaction, the programmed latency value is copied into a down-counter. The counter then drops by one on every clock and stops at zero. Losing the grant does not end the transaction on its own. The master keeps transferring while the count is above zero. Once the count is zero, the stop output rises in the same cycle the grant is low. If the transaction ends first, the counter has no further effect.

Top module: `mlt_top`

## Requirements
- R1: Bits 31:24 (self-test byte) and bits 7:0 (cache-line byte) of `cfg_rdata` always read 00h.
- R2: Bits 23:16 of `cfg_rdata` read 00h when `multi_fn_strap` is 0 and 80h when it is 1.
- R3: Bits 15:8 of `cfg_rdata` hold the latency value. It resets to 00h and takes `cfg_wdata[15:8]` on a clock where `cfg_wr` is 1 and `cfg_be[1]` is 1. Otherwise it is unchanged.
- R4: Writes to byte lanes 0, 2 and 3 are ignored, even when their enables are set.
- R5: A clock with `frame_start` high loads the counter with the latency value. On every later clock of the transaction the counter drops by one.
- R6: `must_stop` is high only while a transaction is active, the count is zero and `gnt` is low. It follows `gnt` in the same cycle.
- R7: If the grant is removed while the count is non-zero, `must_stop` stays low until the count reaches zero, L clocks after the load for a value L.
- R8: If the count expires while `gnt` is high, `must_stop` stays low and rises in the first cycle that `gnt` is low.
- R9: A clock with `frame_end` high (and `frame_start` low) ends the transaction. `must_stop` is then low whatever the count and grant.
- R10: The counter holds at zero rather than wrapping. A latency value of 0 means the count is expired from the first cycle after the load.
- R11: `frame_start` during an active transaction reloads the counter from the current latency value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables for the write, lane 0 = bits 7:0 |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration dword read value |
| multi_fn_strap | input | 1 | High selects the multi-function header value |
| frame_start | input | 1 | Master begins a transaction this cycle |
| frame_end | input | 1 | Master ends its transaction this cycle |
| gnt | input | 1 | Bus grant, high while granted |
| must_stop | output | 1 | Master must end the transaction now |

## Verification
The timer is tried with four grant patterns:
- Grant dropped before expiry, which shows that the count is honoured after grant loss.
- Grant held past expiry and then dropped, which shows the same-cycle response to grant removal.
- Transaction ended before expiry, which shows that an ended count has no effect.
- A zero latency value and a mid-transaction reload, which separate the saturating behaviour from wrapping and from stale counts.

Register access is tried with all byte enables set, with the latency lane masked, and with both strap levels. This separates the writable lane from the fixed ones.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
    localparam int LANE_W   = 8;
    localparam int N_LANES  = 4;
    localparam int DWORD_W  = LANE_W * N_LANES;

    // byte lane positions inside the configuration dword
    localparam int LANE_CLS  = 0;
    localparam int LANE_LAT  = 1;
    localparam int LANE_HDR  = 2;
    localparam int LANE_BIST = 3;

    localparam logic [LANE_W-1:0] HDR_SINGLE = 8'h00;
    localparam logic [LANE_W-1:0] HDR_MULTI  = 8'h80;
    localparam logic [LANE_W-1:0] NOT_IMPL   = 8'h00;

    typedef struct packed {
        logic [LANE_W-1:0] bist;
        logic [LANE_W-1:0] hdr;
        logic [LANE_W-1:0] lat;
        logic [LANE_W-1:0] cls;
    } misc_dword_t;

    typedef struct packed {
        logic              active;
        logic [LANE_W-1:0] count;
    } timer_state_t;

    function automatic logic [LANE_W-1:0] hdr_value(input logic multi);
        return multi ? HDR_MULTI : HDR_SINGLE;
    endfunction

    function automatic logic lane_writable(input int lane);
        return lane == LANE_LAT;
    endfunction
endpackage

// File: rtl/mlt_cfg_reg.sv
module mlt_cfg_reg
    import mlt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [N_LANES-1:0]   be,
    input  logic [DWORD_W-1:0]   wdata,
    input  logic                 strap,
    output logic [DWORD_W-1:0]   rdata,
    output logic [LANE_W-1:0]    lat_val
);
    logic [N_LANES-1:0][LANE_W-1:0] lane_q;
    logic [N_LANES-1:0][LANE_W-1:0] lane_fixed;
    misc_dword_t                    dw;

    assign lane_fixed[LANE_CLS]  = NOT_IMPL;
    assign lane_fixed[LANE_LAT]  = NOT_IMPL;
    assign lane_fixed[LANE_HDR]  = hdr_value(strap);
    assign lane_fixed[LANE_BIST] = NOT_IMPL;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        if (lane_writable(g)) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    lane_q[g] <= '0;
                else if (wr && be[g])
                    lane_q[g] <= wdata[g*LANE_W +: LANE_W];
            end
        end else begin : g_ro
            assign lane_q[g] = lane_fixed[g];
        end
    end

    always_comb begin
        dw.bist = lane_q[LANE_BIST];
        dw.hdr  = lane_q[LANE_HDR];
        dw.lat  = lane_q[LANE_LAT];
        dw.cls  = lane_q[LANE_CLS];
    end

    assign rdata   = dw;
    assign lat_val = dw.lat;
endmodule

// File: rtl/mlt_counter.sv
module mlt_counter
    import mlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              finish,
    input  logic [LANE_W-1:0] load_val,
    output logic              active,
    output logic              expired
);
    timer_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (load) begin
            st_q.active <= 1'b1;
            st_q.count  <= load_val;
        end else begin
            if (finish)
                st_q.active <= 1'b0;
            if (st_q.active && st_q.count != '0)
                st_q.count <= st_q.count - 1'b1;
        end
    end

    assign active  = st_q.active;
    assign expired = (st_q.count == '0);
endmodule

// File: rtl/mlt_term.sv
module mlt_term (
    input  logic active,
    input  logic expired,
    input  logic gnt,
    output logic stop
);
    assign stop = active & expired & ~gnt;
endmodule

// File: rtl/mlt_top.sv
module mlt_top
    import mlt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [N_LANES-1:0] cfg_be,
    input  logic [DWORD_W-1:0] cfg_wdata,
    output logic [DWORD_W-1:0] cfg_rdata,
    input  logic               multi_fn_strap,
    input  logic               frame_start,
    input  logic               frame_end,
    input  logic               gnt,
    output logic               must_stop
);
    logic [LANE_W-1:0] lat_val;
    logic              active;
    logic              expired;

    mlt_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .strap   (multi_fn_strap),
        .rdata   (cfg_rdata),
        .lat_val (lat_val)
    );

    mlt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (frame_start),
        .finish   (frame_end),
        .load_val (lat_val),
        .active   (active),
        .expired  (expired)
    );

    mlt_term u_term (
        .active  (active),
        .expired (expired),
        .gnt     (gnt),
        .stop    (must_stop)
    );
endmodule

// File: rtl/mlt_checker.sv
module mlt_checker (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_rdata,
    input logic        multi_fn_strap,
    input logic        frame_start,
    input logic        frame_end,
    input logic        gnt,
    input logic        must_stop
);
    a_r1_fixed_zero: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[31:24] == 8'h00) && (cfg_rdata[7:0] == 8'h00));

    a_r2_hdr_strap: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[23:16] == (multi_fn_strap ? 8'h80 : 8'h00));

    a_r3_lat_hold: assert property (@(posedge clk) disable iff (rst)
        !(cfg_wr && cfg_be[1]) |=> $stable(cfg_rdata[15:8]));

    a_r6_stop_needs_nogrant: assert property (@(posedge clk) disable iff (rst)
        must_stop |-> !gnt);

    a_r7_nonzero_load_no_stop: assert property (@(posedge clk) disable iff (rst)
        (frame_start && cfg_rdata[15:8] != 8'h00) |=> !must_stop);

    a_r9_end_clears: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !frame_start) |=> !must_stop);

    a_r10_stays_expired: assert property (@(posedge clk) disable iff (rst)
        (must_stop && !frame_start && !frame_end) |=> (must_stop || gnt));
endmodule

bind mlt_top mlt_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_wr         (cfg_wr),
    .cfg_be         (cfg_be),
    .cfg_rdata      (cfg_rdata),
    .multi_fn_strap (multi_fn_strap),
    .frame_start    (frame_start),
    .frame_end      (frame_end),
    .gnt            (gnt),
    .must_stop      (must_stop)
);

// File: tb/sim_mlt_top.sv
module sim_mlt_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        multi_fn_strap;
    logic        frame_start;
    logic        frame_end;
    logic        gnt;
    logic        must_stop;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mlt_top u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .multi_fn_strap(multi_fn_strap), .frame_start(frame_start),
        .frame_end(frame_end), .gnt(gnt), .must_stop(must_stop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // advance to next falling edge; state updated by the preceding rising edge
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [3:0] be, input logic [31:0] d);
        cfg_wr = 1; cfg_be = be; cfg_wdata = d;
        tick();
        cfg_wr = 0; cfg_be = 0; cfg_wdata = 0;
    endtask

    task automatic start_frame();
        frame_start = 1;
        tick();
        frame_start = 0;
    endtask

    task automatic end_frame();
        frame_end = 1;
        tick();
        frame_end = 0;
    endtask

    task automatic t_reset();
        chk("R3 reset dword", cfg_rdata, 32'h0000_0000);
        chk("R6 reset stop", {31'b0, must_stop}, 0);
    endtask

    task automatic t_strap();
        multi_fn_strap = 1; #1;
        chk("R2 strap high", cfg_rdata, 32'h0080_0000);
        multi_fn_strap = 0; #1;
        chk("R2 strap low", cfg_rdata, 32'h0000_0000);
    endtask

    task automatic t_write_lanes();
        cfg_write(4'hF, 32'hFFFF_FFFF);
        chk("R4 all lanes written", cfg_rdata, 32'h0000_FF00);
        cfg_write(4'b1101, 32'h5555_5555);
        chk("R3 masked latency lane", cfg_rdata, 32'h0000_FF00);
        cfg_write(4'b0010, 32'hAB12_3400);
        chk("R3 latency lane only", cfg_rdata, 32'h0000_3400);
        chk("R1 fixed bytes", {cfg_rdata[31:24], cfg_rdata[7:0]}, 0);
    endtask

    // grant lost early: keep going until count hits zero
    task automatic t_grant_lost_early();
        cfg_write(4'b0010, 32'h0000_0300);
        gnt = 0;
        start_frame();
        chk("R7 count 3", {31'b0, must_stop}, 0);
        tick(); chk("R7 count 2", {31'b0, must_stop}, 0);
        tick(); chk("R5 count 1", {31'b0, must_stop}, 0);
        tick(); chk("R7 expired", {31'b0, must_stop}, 1);
        repeat (5) tick();
        chk("R10 held at zero", {31'b0, must_stop}, 1);
        end_frame();
        chk("R9 ended", {31'b0, must_stop}, 0);
        gnt = 1;
    endtask

    task automatic t_grant_held();
        gnt = 1;
        start_frame();
        repeat (6) tick();
        chk("R8 expired grant held", {31'b0, must_stop}, 0);
        gnt = 0; #1;
        chk("R8 grant drop same cycle", {31'b0, must_stop}, 1);
        gnt = 1; #1;
        chk("R6 follows grant", {31'b0, must_stop}, 0);
        end_frame();
    endtask

    task automatic t_end_early();
        gnt = 0;
        start_frame();
        tick();
        end_frame();
        repeat (4) tick();
        chk("R9 no stop after end", {31'b0, must_stop}, 0);
        gnt = 1;
    endtask

    task automatic t_zero_value();
        cfg_write(4'b0010, 32'h0000_0000);
        gnt = 0;
        start_frame();
        chk("R10 zero expires at once", {31'b0, must_stop}, 1);
        end_frame();
        gnt = 1;
    endtask

    task automatic t_reload();
        cfg_write(4'b0010, 32'h0000_0200);
        gnt = 0;
        start_frame();
        tick();
        chk("R11 before reload", {31'b0, must_stop}, 0);
        cfg_write(4'b0010, 32'h0000_0400);
        start_frame();   // reload with 4
        tick(); tick(); tick();
        chk("R11 reload count 1", {31'b0, must_stop}, 0);
        tick();
        chk("R11 reload expired", {31'b0, must_stop}, 1);
        end_frame();
        gnt = 1;
    endtask

    initial begin
        rst = 1; cfg_wr = 0; cfg_be = 0; cfg_wdata = 0;
        multi_fn_strap = 0; frame_start = 0; frame_end = 0; gnt = 1;
        repeat (3) tick();
        rst = 0;
        tick();
        t_reset();
        t_strap();
        t_write_lanes();
        t_grant_lost_early();
        t_grant_held();
        t_end_early();
        t_zero_value();
        t_reload();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule